// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block runs a 24-hour clock. It keeps hours, minutes and seconds as decimal digit pairs. Each field comes out as a 4-bit tens digit and a 4-bit units digit. A digit-per-position display can therefore be driven without a binary-to-decimal converter downstream. A prescaler divides the system clock into a millisecond tick, and a millisecond counter turns those ticks into a one-cycle second strobe. The strobe is also brought out so that timing can be checked without waiting for real time.

Three set inputs let an operator adjust the time. Each input advances one field by one step. Every set input is registered twice inside the block, and only a rising edge has an effect. Holding a set input high therefore gives exactly one step. The inputs are assumed to be debounced upstream. A set step wraps its field within the field's own range and never carries into the next field.

Top module: `bcd_time_counter`

## Requirements
- R1: `secTick` is high for exactly one clock cycle once every `MS_DIV * MS_PER_SEC` cycles. After reset is released, it is first high following clock edge number `MS_DIV * MS_PER_SEC - 1`.
- R2: Seconds advance by one on each `secTick` edge. They count 00 to 59, return to 00 after 59, and carry into minutes only on that return.
- R3: Minutes advance by one when seconds carry. They count 00 to 59, return to 00 after 59, and carry into hours only on that return.
- R4: Hours advance by one when minutes carry. They count 00 to 23 and return to 00 after 23.
- R5: Each set input is registered by two flops. A low-to-high change advances its field by one. The field output changes on the second rising clock edge after the input rises. Holding the input high adds no further steps.
- R6: A set step wraps its field within its own range (59 to 00 for seconds and minutes, 23 to 00 for hours). The next higher field is not changed.
- R7: When a set step and a carry reach the same field on the same edge, the field advances by exactly one.
- R8: Every field is given as two BCD digits. The units digit is 0 to 9. The tens digit is 0 to 5 for seconds and minutes and 0 to 2 for hours. The value is tens*10+units.
- R9: An active-low `rstN` clears all digits and `secTick` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setHourIn | input | 1 | Rising edge advances hours by one |
| setMinIn | input | 1 | Rising edge advances minutes by one |
| setSecIn | input | 1 | Rising edge advances seconds by one |
| hourTens | output | 4 | Hours tens digit (0-2) |
| hourUnits | output | 4 | Hours units digit (0-9) |
| minTens | output | 4 | Minutes tens digit (0-5) |
| minUnits | output | 4 | Minutes units digit (0-9) |
| secTens | output | 4 | Seconds tens digit (0-5) |
| secUnits | output | 4 | Seconds units digit (0-9) |
| secTick | output | 1 | One-cycle strobe marking each elapsed second |

## Verification
A wrong prescaler or millisecond count first shows as a `secTick` that comes too early or too late. That error is visible within one second period of reset. A wrong digit or carry in any field shows up at the next edge that touches that field. The effect is an out-of-range digit, a missed or extra carry into the next field, or a set step that leaks upward. The bench keeps a cycle-exact model of all three fields and of the strobe, and it compares every cycle. It therefore reports a divergence in the cycle where it first appears. It also steers the state into the hour wrap, the set-only wraps and a set-and-carry collision, which would otherwise take a day of simulated time to reach.

// File: rtl/bcd_clock_pkg.sv
`timescale 1ns/1ps
package bcd_clock_pkg;

  localparam int FIELDS     = 3;
  localparam int FIELD_SEC  = 0;
  localparam int FIELD_MIN  = 1;
  localparam int FIELD_HOUR = 2;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic secTick;
    logic setHour;
    logic setMin;
    logic setSec;
  } clk_strobe_t;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd_pair_t;

  // next value of a digit pair that wraps to 00 after lastTens:lastUnits
  function automatic bcd_pair_t bcdNext(bcd_pair_t cur, logic [3:0] lastTens,
                                        logic [3:0] lastUnits);
    bcd_pair_t nxt;
    if (cur.tens == lastTens && cur.units == lastUnits) begin
      nxt = '0;
    end else if (cur.units == 4'd9) begin
      nxt.tens  = cur.tens + 4'd1;
      nxt.units = 4'd0;
    end else begin
      nxt.tens  = cur.tens;
      nxt.units = cur.units + 4'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/time_ctrl.sv
`timescale 1ns/1ps
module time_ctrl
  import bcd_clock_pkg::*;
#(
  parameter int MS_DIV     = 50000,
  parameter int MS_PER_SEC = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  setRaw,   // {hour, minute, second}
  output clk_strobe_t strobes
);

  localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
  localparam int MS_W  = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_PER_SEC - 1);

  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;
  logic             msTick;
  logic [2:0]       syncNew, syncOld, setPulse;

  assign msTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (msTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (msTick) begin
      msCnt <= (msCnt == MS_LAST) ? '0 : msCnt + 1'b1;
    end
  end

  // two-flop sampling and rising-edge detection for each set input
  for (genvar g = 0; g < 3; g++) begin : gSetEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncNew[g] <= 1'b0;
        syncOld[g] <= 1'b0;
      end else begin
        syncNew[g] <= setRaw[g];
        syncOld[g] <= syncNew[g];
      end
    end
    assign setPulse[g] = syncNew[g] & ~syncOld[g];
  end

  assign strobes.secTick = msTick && (msCnt == MS_LAST);
  assign strobes.setHour = setPulse[2];
  assign strobes.setMin  = setPulse[1];
  assign strobes.setSec  = setPulse[0];

endmodule

// File: rtl/time_datapath.sv
`timescale 1ns/1ps
module time_datapath
  import bcd_clock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  clk_strobe_t strobes,
  output bcd_pair_t   secPair,
  output bcd_pair_t   minPair,
  output bcd_pair_t   hourPair
);

  bcd_pair_t        pairQ [FIELDS];
  logic [FIELDS-1:0] carryIn;
  logic [FIELDS-1:0] setVec;
  logic [FIELDS-1:0] advance;

  assign setVec     = {strobes.setHour, strobes.setMin, strobes.setSec};
  assign carryIn[0] = strobes.secTick;
  assign advance    = carryIn | setVec;   // set and carry together give one step

  for (genvar g = 0; g < FIELDS; g++) begin : gField
    localparam logic [3:0] LAST_T = (g == FIELD_HOUR) ? 4'd2 : 4'd5;
    localparam logic [3:0] LAST_U = (g == FIELD_HOUR) ? 4'd3 : 4'd9;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pairQ[g] <= '0;
      end else if (advance[g]) begin
        pairQ[g] <= bcdNext(pairQ[g], LAST_T, LAST_U);
      end
    end

    if (g < FIELDS - 1) begin : gCarry
      logic atLast;
      assign atLast       = (pairQ[g].tens == LAST_T) && (pairQ[g].units == LAST_U);
      // only the timed carry propagates; a set step never carries
      assign carryIn[g+1] = carryIn[g] & atLast;
    end
  end

  assign secPair  = pairQ[FIELD_SEC];
  assign minPair  = pairQ[FIELD_MIN];
  assign hourPair = pairQ[FIELD_HOUR];

endmodule

// File: rtl/bcd_time_counter.sv
`timescale 1ns/1ps
module bcd_time_counter
  import bcd_clock_pkg::*;
#(
  parameter int MS_DIV     = 50000,
  parameter int MS_PER_SEC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setHourIn,
  input  logic       setMinIn,
  input  logic       setSecIn,
  output logic [3:0] hourTens,
  output logic [3:0] hourUnits,
  output logic [3:0] minTens,
  output logic [3:0] minUnits,
  output logic [3:0] secTens,
  output logic [3:0] secUnits,
  output logic       secTick
);

  clk_strobe_t strobes;
  bcd_pair_t   secPair, minPair, hourPair;

  time_ctrl #(.MS_DIV(MS_DIV), .MS_PER_SEC(MS_PER_SEC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .setRaw  ({setHourIn, setMinIn, setSecIn}),
    .strobes (strobes)
  );

  time_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .secPair  (secPair),
    .minPair  (minPair),
    .hourPair (hourPair)
  );

  assign hourTens  = hourPair.tens;
  assign hourUnits = hourPair.units;
  assign minTens   = minPair.tens;
  assign minUnits  = minPair.units;
  assign secTens   = secPair.tens;
  assign secUnits  = secPair.units;
  assign secTick   = strobes.secTick;

endmodule

// File: rtl/bcd_time_counter_chk.sv
`timescale 1ns/1ps
module bcd_time_counter_chk
  import bcd_clock_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input clk_strobe_t strobes,
  input logic [3:0]  hourTens,
  input logic [3:0]  hourUnits,
  input logic [3:0]  minTens,
  input logic [3:0]  minUnits,
  input logic [3:0]  secTens,
  input logic [3:0]  secUnits,
  input logic        secTick
);

  logic secAtLast, minAtLast, hourAtLast;
  assign secAtLast  = (secTens == 4'd5) && (secUnits == 4'd9);
  assign minAtLast  = (minTens == 4'd5) && (minUnits == 4'd9);
  assign hourAtLast = (hourTens == 4'd2) && (hourUnits == 4'd3);

  p_units_bcd_r8: assert property (@(posedge clk) disable iff (!rstN)
    secUnits <= 4'd9 && minUnits <= 4'd9 && hourUnits <= 4'd9);

  p_tens_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    secTens <= 4'd5 && minTens <= 4'd5 && hourTens <= 4'd2);

  p_hour_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    hourTens < 4'd2 || hourUnits <= 4'd3);

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.secTick || strobes.setSec) |=> $stable({secTens, secUnits}));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.setMin || (strobes.secTick && secAtLast)) |=> $stable({minTens, minUnits}));

  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.secTick && secAtLast && minAtLast && hourAtLast) |=>
      (hourTens == 4'd0 && hourUnits == 4'd0 && minTens == 4'd0 && minUnits == 4'd0));

  p_set_no_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setMin && !strobes.secTick && !strobes.setHour && minAtLast) |=>
      ($stable({hourTens, hourUnits}) && minTens == 4'd0 && minUnits == 4'd0));

endmodule

bind bcd_time_counter bcd_time_counter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strobes   (strobes),
  .hourTens  (hourTens),
  .hourUnits (hourUnits),
  .minTens   (minTens),
  .minUnits  (minUnits),
  .secTens   (secTens),
  .secUnits  (secUnits),
  .secTick   (secTick)
);

// File: tb/test_bcd_time_counter.sv
`timescale 1ns/1ps
module test_bcd_time_counter;

  localparam int DIV = 4;
  localparam int PER = 5;
  localparam int SEC_CYC = DIV * PER;

  typedef struct {
    int  hr;
    int  mn;
    int  sc;
    bit  tick;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setHourIn = 1'b0, setMinIn = 1'b0, setSecIn = 1'b0;
  logic [3:0] hourTens, hourUnits, minTens, minUnits, secTens, secUnits;
  logic secTick;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  exp_t expQ[$];

  // reference state (binary integers)
  int refPre = 0, refMs = 0, refSec = 0, refMin = 0, refHr = 0;
  bit rNew[3] = '{0, 0, 0};
  bit rOld[3] = '{0, 0, 0};
  bit sawCollision = 0, sawSecSetWrap = 0, sawHourWrap = 0;

  bcd_time_counter #(.MS_DIV(DIV), .MS_PER_SEC(PER)) i_bcd_time_counter (
    .clk(clk), .rstN(rstN),
    .setHourIn(setHourIn), .setMinIn(setMinIn), .setSecIn(setSecIn),
    .hourTens(hourTens), .hourUnits(hourUnits),
    .minTens(minTens), .minUnits(minUnits),
    .secTens(secTens), .secUnits(secUnits),
    .secTick(secTick)
  );

  always #2 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hrVal();  return hourTens * 10 + hourUnits; endfunction
  function automatic int minVal(); return minTens * 10 + minUnits;   endfunction
  function automatic int secVal(); return secTens * 10 + secUnits;   endfunction

  // reference model: pushes one expected item per active clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      refPre = 0; refMs = 0; refSec = 0; refMin = 0; refHr = 0;
      for (int k = 0; k < 3; k++) begin rNew[k] = 0; rOld[k] = 0; end
    end else begin
      bit pt, st, ps, pm, ph, cs, cm;
      exp_t e;
      pt = (refPre == DIV - 1);
      st = pt && (refMs == PER - 1);
      ps = rNew[0] && !rOld[0];
      pm = rNew[1] && !rOld[1];
      ph = rNew[2] && !rOld[2];
      for (int k = 0; k < 3; k++) rOld[k] = rNew[k];
      rNew[0] = setSecIn; rNew[1] = setMinIn; rNew[2] = setHourIn;
      cs = st && (refSec == 59);
      cm = cs && (refMin == 59);
      if (st && ps) sawCollision = 1;
      if (ps && !st && refSec == 59) sawSecSetWrap = 1;
      if (cm && refHr == 23) sawHourWrap = 1;
      refPre = pt ? 0 : refPre + 1;
      if (pt) refMs = (refMs == PER - 1) ? 0 : refMs + 1;
      if (st || ps) refSec = (refSec + 1) % 60;
      if (cs || pm) refMin = (refMin + 1) % 60;
      if (cm || ph) refHr = (refHr + 1) % 24;
      e.hr = refHr; e.mn = refMin; e.sc = refSec;
      e.tick = (refPre == DIV - 1) && (refMs == PER - 1);
      expQ.push_back(e);
    end
  end

  // monitor: compares each expected item with the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(secTens == 4'(e.sc / 10) && secUnits == 4'(e.sc % 10), "R2 R8 seconds", secVal(), e.sc);
        check(minTens == 4'(e.mn / 10) && minUnits == 4'(e.mn % 10), "R3 R8 minutes", minVal(), e.mn);
        check(hourTens == 4'(e.hr / 10) && hourUnits == 4'(e.hr % 10), "R4 R8 hours", hrVal(), e.hr);
        check(secTick == e.tick, "R1 secTick", int'(secTick), int'(e.tick));
      end
    end
  end

  task automatic press(int which, int holdCyc);
    @(negedge clk);
    case (which)
      0: setSecIn = 1'b1;
      1: setMinIn = 1'b1;
      default: setHourIn = 1'b1;
    endcase
    repeat (holdCyc) @(negedge clk);
    setSecIn = 1'b0; setMinIn = 1'b0; setHourIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, h0, s0, lim;
    // R9: reset state
    repeat (3) @(negedge clk);
    check(hrVal() == 0 && minVal() == 0 && secVal() == 0, "R9 digits in reset", secVal(), 0);
    check(secTick == 1'b0, "R9 tick in reset", int'(secTick), 0);
    rstN = 1'b1;

    // R1: first tick after SEC_CYC-1 edges, then every SEC_CYC edges
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!secTick && cyc < 1000);
    check(cyc == SEC_CYC - 1, "R1 first tick edge", cyc, SEC_CYC - 1);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!secTick && cyc < 1000);
    check(cyc == SEC_CYC, "R1 tick period", cyc, SEC_CYC);

    // R5: latency of two edges and no repeat while held
    @(negedge clk);
    h0 = hrVal();
    setHourIn = 1'b1;
    @(negedge clk);
    check(hrVal() == h0, "R5 no change after one edge", hrVal(), h0);
    @(negedge clk);
    check(hrVal() == h0 + 1, "R5 step on second edge", hrVal(), h0 + 1);
    repeat (10) @(negedge clk);
    check(hrVal() == h0 + 1, "R5 held input single step", hrVal(), h0 + 1);
    setHourIn = 1'b0;
    repeat (3) @(negedge clk);

    // R4: bring to 23:59 with set steps, then wait for the day wrap
    lim = 0;
    while (!(refHr == 23 && refMin == 59) && lim < 400) begin
      if (refHr != 23) press(2, 2); else press(1, 2);
      lim++;
    end
    lim = 0;
    while (!sawHourWrap && lim < 3000) begin @(negedge clk); lim++; end
    check(sawHourWrap, "R4 day wrap reached", int'(sawHourWrap), 1);
    check(hrVal() == 0 && minVal() == 0, "R4 00:00 after 23:59:59", hrVal() * 100 + minVal(), 0);

    // R6: minute set wrap leaves hours unchanged
    lim = 0;
    while (refMin != 59 && lim < 200) begin press(1, 2); lim++; end
    lim = 0;
    while (refSec > 50 && lim < 2000) begin @(negedge clk); lim++; end
    h0 = hrVal();
    press(1, 2);
    check(minVal() == 0, "R6 minute set wraps to 00", minVal(), 0);
    check(hrVal() == h0, "R6 minute set wrap no carry", hrVal(), h0);

    // R6: seconds set wrap (verified cycle by cycle, recorded by model)
    lim = 0;
    while (!sawSecSetWrap && lim < 200) begin press(0, 2); lim++; end
    check(sawSecSetWrap, "R6 seconds set wrap exercised", int'(sawSecSetWrap), 1);

    // R7: set step on the same edge as a second tick
    lim = 0;
    do begin @(negedge clk); lim++; end
      while (!(refPre == DIV - 2 && refMs == PER - 1 && refSec < 58) && lim < 5000);
    s0 = secVal();
    setSecIn = 1'b1;
    repeat (2) @(negedge clk);
    check(secVal() == s0 + 1, "R7 collision single step", secVal(), s0 + 1);
    check(sawCollision, "R7 collision exercised", int'(sawCollision), 1);
    setSecIn = 1'b0;
    repeat (5) @(negedge clk);

    // R9: asynchronous reset mid-run, checked before any clock edge
    @(negedge clk);
    #1.5;
    rstN = 1'b0;
    #0.2;
    check(hrVal() == 0 && minVal() == 0 && secVal() == 0, "R9 async clear", secVal() + minVal() + hrVal(), 0);
    check(secTick == 1'b0, "R9 async tick clear", int'(secTick), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (SEC_CYC * 3) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule